// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers up to 128 level-sensitive peripheral interrupt lines and produces one interrupt request per CPU, for one or two CPUs. Each CPU owns a private bank of registers: a group of enable words, then a group of status words. A status word shows the live, synchronized state of 32 source lines. A CPU's request output is high while any source is both active and enabled in that CPU's bank. Software steers a source to a CPU by setting its enable bit in that CPU's bank only.

There is no priority logic, no vector and no pending queue. A handler reads every status word of its bank and masks the result with its enables. Enable words are plain read/write words with no set-bit or clear-bit aliases, so changing one bit takes a read-modify-write.

Access is through a 32-bit register port with a byte address and a bank select. Reads are combinational from the address and the bank select. A write takes effect on the clock edge on which `req_i` and `wr_i` are both high.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset, every enable bit of every bank reads 0 and every `irq_o` bit is 0.
- R2: Each source passes through two flip-flops before it reaches status. A change on `src_i` shows in a status read after the second rising edge, and not after the first.
- R3: Status words are read-only. A write to a status address leaves status, the enables and `irq_o` unchanged.
- R4: Enable words are plain 32-bit read/write words. A write replaces the whole addressed word and changes no other word.
- R5: With W = NUM_SRC/32 words per group, enable word w (sources 32w..32w+31) is at byte offset 4*(W-1-w). Status word w is at byte offset 4*W + 4*(W-1-w), so the highest-numbered word has the lowest address in each group. Bit b of word w is source 32w+b.
- R6: `irq_o[c]` is a register that is set when any bit of (status AND enable of bank c) is set, and clear otherwise. A source change reaches `irq_o` on the third rising edge, and an enable write reaches it one edge after the write edge.
- R7: `bank_sel_i` selects which CPU's bank a read or a write uses. A write to one bank leaves the other bank unchanged.
- R8: A source enabled in both banks drives both `irq_o` bits. A source enabled in only one bank drives only that bank's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources, active high |
| bank_sel_i | input | max(1,clog2(NUM_CPU)) | Selects the CPU bank for register access |
| req_i | input | 1 | Register access strobe |
| wr_i | input | 1 | High for a write when `req_i` is high |
| addr_i | input | clog2(NUM_SRC/4) | Byte address within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed word of the selected bank |
| irq_o | output | NUM_CPU | One interrupt request per CPU |

## Verification
The embedded assertions check three things on every cycle. Enables change only on a write to an enable address. A bank with no enables has no request. A status read matches inputs that have been steady for long enough. The bench scenarios cover the rest: the reversed word layout, the exact edge on which a request rises and falls, the independence of the two banks, and routing one source to one CPU, the other CPU or both.

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_SRC-1:0]                     src_i,
  input  logic [(NUM_CPU > 1 ? $clog2(NUM_CPU) : 1)-1:0] bank_sel_i,
  input  logic                                   req_i,
  input  logic                                   wr_i,
  input  logic [$clog2(NUM_SRC/4)-1:0]           addr_i,
  input  logic [31:0]                            wdata_i,
  output logic [31:0]                            rdata_o,
  output logic [NUM_CPU-1:0]                     irq_o
);
  localparam int WORDS = NUM_SRC / 32;
  localparam int AW    = $clog2(NUM_SRC / 4);

  logic [NUM_SRC-1:0] s1_q, s2_q;
  logic [NUM_SRC-1:0] en_q [NUM_CPU];
  logic [NUM_CPU-1:0] irq_q;

  logic [AW-3:0] widx;
  logic          is_stat;
  int            word_sel;
  logic          wr_en;

  assign widx     = addr_i[AW-1:2];
  assign is_stat  = int'(widx) >= WORDS;
  assign word_sel = WORDS - 1 - (int'(widx) % WORDS);
  assign wr_en    = req_i && wr_i && !is_stat;
  assign irq_o    = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_stat) begin
      rdata_o = s2_q[word_sel*32 +: 32];
    end else begin
      for (int c = 0; c < NUM_CPU; c++)
        if (int'(bank_sel_i) == c) rdata_o = en_q[c][word_sel*32 +: 32];
    end
  end

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[c]  <= '0;
          irq_q[c] <= 1'b0;
        end else begin
          if (wr_en && int'(bank_sel_i) == c)
            en_q[c][word_sel*32 +: 32] <= wdata_i;
          irq_q[c] <= |(s2_q & en_q[c]);
        end
      end

      assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && int'(bank_sel_i) == c) |=> $stable(en_q[c]));

      assert_stat_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && wr_i && is_stat) |=> $stable(en_q[c]));

      assert_no_enable_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[c] == '0 && $past(en_q[c]) == '0) |-> !irq_o[c]);
    end
  endgenerate

  logic [1:0] alive_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alive_q <= '0;
    else if (alive_q != 2'd3) alive_q <= alive_q + 2'd1;
  end

  assert_stat_follows_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q == 2'd3 && is_stat && src_i == $past(src_i) && src_i == $past(src_i, 2))
      |-> rdata_o == src_i[word_sel*32 +: 32]);
endmodule

// File: tb/lvl_irq_agg_tb_top.sv
module lvl_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [0:0]  bsel = '0;
  logic        req = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_irq_agg #(.NUM_SRC(64), .NUM_CPU(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bank_sel_i(bsel), .req_i(req),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // {src, en bank0, en bank1, expected irq}
  localparam logic [193:0] VEC [6] = '{
    {64'h1, 64'h1, 64'h0, 2'b01},
    {64'h1 << 40, 64'h1 << 40, 64'h1 << 40, 2'b11},
    {64'h1 << 33, 64'h1 << 32, 64'h1 << 33, 2'b10},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 2'b00},
    {64'h1 << 63, 64'h1 << 63, 64'h0, 2'b01},
    {64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic b, logic [3:0] a, logic [31:0] d);
    bsel = b; addr = a; wdata = d; req = 1'b1; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic rreg(logic b, logic [3:0] a, output logic [31:0] d);
    bsel = b; addr = a; #1; d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    logic [31:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    rreg(0, 4'd0, d); chk("R1 en b0 w1", 64'(d), 0);
    rreg(0, 4'd4, d); chk("R1 en b0 w0", 64'(d), 0);
    rreg(1, 4'd0, d); chk("R1 en b1 w1", 64'(d), 0);

    // R2 two-flop synchronizer, R5 status layout
    src = 64'h0000_0005_0000_000A;
    cyc(1);
    rreg(0, 4'd12, d); chk("R2 status after one edge", 64'(d), 0);
    cyc(1);
    rreg(0, 4'd12, d); chk("R2 R5 status word0", 64'(d), 64'hA);
    rreg(0, 4'd8, d);  chk("R2 R5 status word1", 64'(d), 64'h5);

    // R3 status writes ignored
    wreg(0, 4'd12, 32'hFFFF_FFFF);
    rreg(0, 4'd12, d); chk("R3 status unchanged", 64'(d), 64'hA);
    rreg(0, 4'd4, d);  chk("R3 enable unchanged", 64'(d), 0);
    cyc(1);
    chk("R3 irq unchanged", 64'(irq), 0);

    // R4 plain word write, R7 bank independence
    wreg(0, 4'd0, 32'h1234_5678);
    rreg(0, 4'd0, d); chk("R4 readback", 64'(d), 64'h1234_5678);
    rreg(0, 4'd4, d); chk("R4 other word", 64'(d), 0);
    rreg(1, 4'd0, d); chk("R7 other bank", 64'(d), 0);
    wreg(0, 4'd0, 32'h0);
    src = '0;
    cyc(3);

    // R6 timing
    src = 64'h1;
    cyc(3);
    wreg(0, 4'd4, 32'h1);
    chk("R6 irq not yet after enable", 64'(irq), 0);
    cyc(1);
    chk("R6 irq one edge after enable", 64'(irq), 2'b01);
    src = 64'h0;
    cyc(2);
    chk("R6 irq held two edges", 64'(irq), 2'b01);
    cyc(1);
    chk("R6 irq fell on third edge", 64'(irq), 2'b00);

    // table: R5 word order, R6, R8 routing
    for (int i = 0; i < 6; i++) begin
      logic [63:0] vs, v0, v1;
      logic [1:0]  ve;
      {vs, v0, v1, ve} = VEC[i];
      wreg(0, 4'd4, v0[31:0]); wreg(0, 4'd0, v0[63:32]);
      wreg(1, 4'd4, v1[31:0]); wreg(1, 4'd0, v1[63:32]);
      src = vs;
      cyc(4);
      chk($sformatf("R5 R6 R8 vector %0d irq", i), 64'(irq), 64'(ve));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule